// File: doc/BRIEF.md
# HDLC Data-Link Message Transmitter

This block sends one fixed-length data-link message as a bit-oriented HDLC stream. Software first loads the message bytes into a small internal store through a write port, then picks one of two lengths (76 or 82 bytes) and issues a start command. The block wraps the message in flag octets, shifts every byte out least-significant bit first, follows it with a 16-bit frame check sequence, and inserts a zero after any run of five ones so that the flag pattern never appears inside the frame.

The output advances by exactly one bit on every clock edge at which the bit-enable strobe is high. A surrounding framer raises that strobe whenever it has a free overhead bit position to fill, so the bit stream can be spread thinly over a much faster line. While no message is pending, the block keeps sending flag octets. At the end of each message it raises a one-cycle completion pulse, and a busy output shows whether a message is queued or on its way out.

Top module: `lapd_tx`

## Requirements
- R1: After reset, tx_bit is 0, busy is 0 and done_irq is 0. While idle, the stream is an unbroken series of flag octets 0x7E.
- R2: A write with wr_en high stores wr_data at wr_addr (0 to 81). Byte k of the store becomes the k-th byte of the next message.
- R3: A start pulse while busy is 0 drives busy to 1 on the following cycle. The message body begins once the flag octet being sent has finished, and that flag serves as the opening flag.
- R4: len_sel is sampled when start is accepted (0 selects 76 bytes, 1 selects 82 bytes). Changes to len_sel during a message have no effect on that message.
- R5: Each byte of the message, and of the check sequence, is sent least-significant bit first.
- R6: The frame check sequence is the bit-reflected CRC-16 with polynomial x^16+x^12+x^5+1 (reflected constant 0x8408) and preset 0xFFFF, taken over the message bytes. It is sent complemented, low byte first.
- R7: After five consecutive 1 bits from the message or check sequence, one 0 bit is inserted, including just before the closing flag. Flag bits are never stuffed.
- R8: One closing flag follows the check sequence. After it, idle flags resume.
- R9: The bit stream advances only on clock edges where bit_en is 1. While bit_en is 0, tx_bit holds its value.
- R10: done_irq is high for exactly one cycle per message, on the cycle in which the last bit of the closing flag first appears on tx_bit. busy is 0 in that same cycle.
- R11: A start pulse while busy is 1 is ignored: no extra message is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Message store write strobe |
| wr_addr | input | 7 | Message store byte address |
| wr_data | input | 8 | Message store write data |
| len_sel | input | 1 | Length select: 0 = 76 bytes, 1 = 82 bytes |
| start | input | 1 | Send command, single-cycle pulse |
| bit_en | input | 1 | Bit-slot strobe from the outer framer |
| tx_bit | output | 1 | Serial output bit |
| busy | output | 1 | Message queued or in transmission |
| done_irq | output | 1 | One-cycle pulse at message completion |

## Verification
busy is due one cycle after an accepted start. Every other result is tied to bit slots rather than cycles: the bit on tx_bit at a falling edge with bit_en high is the one consumed at the next rising edge, and done_irq rises in the same cycle the last closing-flag bit first appears. For this reason the bench drives all inputs just after rising edges and samples only at falling edges. A monitor rebuilds frames from the sampled bits by removing stuffing and splitting at flags, and then compares each frame against a queue that the driver filled with the message bytes and an independently computed check sequence. The monitor also confirms that the completion-pulse count matches the frame count, and checks that tx_bit is held across every slot in which bit_en was low.

// File: rtl/lapd_tx_pkg.sv
package lapd_tx_pkg;

    localparam int MSG_LEN_SHORT = 76;
    localparam int MSG_LEN_LONG  = 82;

    localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
    localparam logic [15:0] FCS_PRESET  = 16'hFFFF;
    localparam logic [15:0] FCS_POLY_RF = 16'h8408;

    // Position of the bit source inside the outgoing stream
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BODY  = 2'd1,
        PH_CLOSE = 2'd2
    } phase_e;

    // One candidate bit offered to the stuffing stage
    typedef struct packed {
        logic val;
        logic stuffable;
    } line_bit_t;

    // One serial step of the reflected CCITT check
    function automatic logic [15:0] fcs_step(logic [15:0] cur, logic din);
        logic [15:0] sh;
        sh = cur >> 1;
        return (cur[0] ^ din) ? (sh ^ FCS_POLY_RF) : sh;
    endfunction

endpackage

// File: rtl/lapd_msg_ram.sv
module lapd_msg_ram #(
    parameter int DEPTH = 82,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < DEPTH_V)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if ({1'b0, raddr} < DEPTH_V) begin
            rdata = mem[raddr];
        end
    end
endmodule

// File: rtl/lapd_fcs16.sv
module lapd_fcs16
    import lapd_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        step,
    input  logic        din,
    output logic [15:0] fcs
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fcs <= FCS_PRESET;
        end else if (step) begin
            fcs <= fcs_step(fcs, din);
        end
    end
endmodule

// File: rtl/lapd_stuffer.sv
module lapd_stuffer
    import lapd_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  line_bit_t src,
    output logic      src_take,
    output logic      tx_bit
);
    logic       out_q;
    logic [2:0] ones_q;
    logic       stuff_now;

    assign stuff_now = (ones_q == 3'd5);
    assign src_take  = bit_en && !stuff_now;
    assign tx_bit    = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= 1'b0;       // first bit of the leading flag
            ones_q <= 3'd0;
        end else if (bit_en) begin
            if (stuff_now) begin
                out_q  <= 1'b0;
                ones_q <= 3'd0;
            end else begin
                out_q  <= src.val;
                ones_q <= (src.stuffable && src.val) ? ones_q + 3'd1 : 3'd0;
            end
        end
    end

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_bit)); // R9

    AST_ZERO_AFTER_FIVE: assert property (@(posedge clk) disable iff (rst)
        (ones_q == 3'd5) && bit_en |=> !tx_bit); // R7
endmodule

// File: rtl/lapd_tx.sv
module lapd_tx
    import lapd_tx_pkg::*;
#(
    parameter int LEN_A = MSG_LEN_SHORT,
    parameter int LEN_B = MSG_LEN_LONG
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [6:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       len_sel,
    input  logic       start,
    input  logic       bit_en,
    output logic       tx_bit,
    output logic       busy,
    output logic       done_irq
);
    localparam int DEPTH = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int AW    = 7;
    localparam int CNT_W = $clog2(DEPTH + 2);
    localparam logic [CNT_W-1:0] LEN_A_V = CNT_W'(LEN_A);
    localparam logic [CNT_W-1:0] LEN_B_V = CNT_W'(LEN_B);

    phase_e           phase_q;
    logic [CNT_W-1:0] byte_q;
    logic [2:0]       bit_q;
    logic             pend_q;
    logic [CNT_W-1:0] len_q;
    logic             irq_q;

    logic [7:0]  ram_rd;
    logic [15:0] fcs;
    logic [15:0] fcs_out;
    line_bit_t   src;
    logic        src_take;
    logic        in_data;
    logic        accept;

    assign busy     = pend_q || (phase_q != PH_IDLE);
    assign accept   = start && !busy;
    assign done_irq = irq_q;
    assign in_data  = (phase_q == PH_BODY) && (byte_q < len_q);
    assign fcs_out  = ~fcs;

    lapd_msg_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (AW'(byte_q)),
        .rdata (ram_rd)
    );

    lapd_fcs16 u_fcs (
        .clk   (clk),
        .rst   (rst),
        .clear (phase_q == PH_IDLE),
        .step  (src_take && in_data),
        .din   (src.val),
        .fcs   (fcs)
    );

    lapd_stuffer u_stuff (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .src      (src),
        .src_take (src_take),
        .tx_bit   (tx_bit)
    );

    // Bit source: flag octet, message byte or check-sequence byte
    always_comb begin
        src.val       = FLAG_OCTET[bit_q];
        src.stuffable = 1'b0;
        if (phase_q == PH_BODY) begin
            src.stuffable = 1'b1;
            if (in_data) begin
                src.val = ram_rd[bit_q];
            end else if (byte_q == len_q) begin
                src.val = fcs_out[{1'b0, bit_q}];
            end else begin
                src.val = fcs_out[{1'b1, bit_q}];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            byte_q  <= '0;
            bit_q   <= 3'd1;      // bit 0 of the first flag is already on the line
            pend_q  <= 1'b0;
            len_q   <= LEN_A_V;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (accept) begin
                pend_q <= 1'b1;
                len_q  <= len_sel ? LEN_B_V : LEN_A_V;
            end
            if (src_take) begin
                bit_q <= bit_q + 3'd1;
                if (bit_q == 3'd7) begin
                    unique case (phase_q)
                        PH_IDLE: begin
                            if (pend_q) begin
                                phase_q <= PH_BODY;
                                byte_q  <= '0;
                                pend_q  <= 1'b0;
                            end
                        end
                        PH_BODY: begin
                            if (byte_q == len_q + CNT_W'(1)) begin
                                phase_q <= PH_CLOSE;
                            end else begin
                                byte_q <= byte_q + CNT_W'(1);
                            end
                        end
                        PH_CLOSE: begin
                            phase_q <= PH_IDLE;
                            irq_q   <= 1'b1;
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R3

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq); // R10

    AST_IRQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> !busy); // R10

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        busy && !$rose(busy) |-> $stable(len_q)); // R4
endmodule

// File: tb/lapd_tx_test.sv
`timescale 1ns/1ps
module lapd_tx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       len_sel = 1'b0;
    logic       start = 1'b0;
    logic       bit_en = 1'b0;
    logic       tx_bit, busy, done_irq;

    always #4 clk = ~clk;   // 125 MHz

    lapd_tx uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .len_sel(len_sel), .start(start), .bit_en(bit_en),
        .tx_bit(tx_bit), .busy(busy), .done_irq(done_irq)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Scoreboard queues filled by the driver
    logic [7:0] exp_bytes[$];
    int         exp_len[$];

    function automatic logic [7:0] pattern(int pat, int i);
        case (pat)
            0: return 8'hFF;
            1: return 8'h00;
            2: return 8'(i);
            3: return 8'((i * 37 + 11) ^ (i >> 1));
            default: return 8'h7E;
        endcase
    endfunction

    function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int j = 0; j < 8; j++) begin
            if (r[0] != d[j]) r = (r >> 1) ^ 16'h8408;
            else              r = r >> 1;
        end
        return r;
    endfunction

    // bit_en pattern source
    int en_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (rst)               bit_en = 1'b0;
            else if (en_mode == 0) bit_en = 1'b1;
            else if (en_mode == 1) bit_en = lfsr[0];
            else                   bit_en = (lfsr[1:0] == 2'b00);
        end
    end

    // Monitor: destuff, split at flags, compare
    bit   bits[$];
    int   ones = 0;
    int   irq_count = 0;
    int   frames_seen = 0;
    int   idle_flags = 0;
    int   stall_bad = 0;
    int   bits_taken = 0;
    logic [7:0] first_oct = '0;
    logic prev_en = 1'b0;
    logic prev_bit = 1'b0;
    bit   have_prev = 1'b0;

    task automatic frame_end();
        int n, len, mism_data, mism_fcs;
        logic [7:0] d, e;
        if (bits.size() >= 7) begin
            repeat (7) void'(bits.pop_back());
        end else begin
            bits.delete();
        end
        n = bits.size();
        if (n == 0) begin
            idle_flags++;
        end else begin
            frames_seen++;
            if (exp_len.size() == 0) begin
                check(1'b0, "R11", "frame without accepted start, bits", n, 0);
            end else begin
                len = exp_len.pop_front();
                check(n == (len + 2) * 8, "R4", "frame bit count", n, (len + 2) * 8);
                mism_data = 0;
                mism_fcs  = 0;
                for (int k = 0; k < len + 2; k++) begin
                    e = exp_bytes.pop_front();
                    d = '0;
                    for (int j = 0; j < 8; j++) begin
                        if (k * 8 + j < n) d[j] = bits[k * 8 + j];
                    end
                    if (d != e) begin
                        if (k < len) mism_data++;
                        else         mism_fcs++;
                    end
                end
                check(mism_data == 0, "R5", "message bytes differing (R2 content, LSB first)", mism_data, 0);
                check(mism_fcs == 0, "R6", "check-sequence bytes differing", mism_fcs, 0);
                check(irq_count == frames_seen, "R10", "done_irq pulses at frame end", irq_count, frames_seen);
            end
        end
        bits.delete();
    endtask

    task automatic take_bit(bit b);
        if (bits_taken < 8) first_oct[bits_taken] = b;
        bits_taken++;
        if (b) begin
            ones++;
            bits.push_back(1'b1);
            if (ones == 7) check(1'b0, "R7", "run of ones in stream", ones, 6);
        end else begin
            if (ones == 5)      ones = 0;          // stuffed zero
            else if (ones == 6) begin frame_end(); ones = 0; end
            else begin bits.push_back(1'b0); ones = 0; end
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (have_prev && !prev_en && tx_bit != prev_bit) stall_bad++;
                if (done_irq) irq_count++;
                if (bit_en) take_bit(tx_bit);
                prev_en   = bit_en;
                prev_bit  = tx_bit;
                have_prev = 1'b1;
            end
        end
    end

    // Driver: load store, push expectations, issue start
    task automatic send_msg(int len, int pat, bit spurious);
        logic [15:0] c;
        logic [7:0]  v;
        while (busy) tick();
        c = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            v = pattern(pat, i);
            wr_en = 1'b1; wr_addr = 7'(i); wr_data = v;   // R2
            tick();
            exp_bytes.push_back(v);
            c = ref_crc(c, v);
        end
        wr_en = 1'b0;
        c = ~c;
        exp_bytes.push_back(c[7:0]);
        exp_bytes.push_back(c[15:8]);
        exp_len.push_back(len);
        start = 1'b1;
        len_sel = (len == 82);
        tick();
        start = 1'b0;
        check(busy == 1'b1, "R3", "busy one cycle after start", busy, 1);
        if (spurious) begin
            repeat (300) tick();
            start = 1'b1;
            len_sel = ~len_sel;   // R4: must not affect the running message
            tick();
            start = 1'b0;
            check(busy == 1'b1, "R11", "busy during message after extra start", busy, 1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state
        check(tx_bit == 1'b0, "R1", "tx_bit after reset", tx_bit, 0);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(done_irq == 1'b0, "R1", "done_irq after reset", done_irq, 0);
        repeat (60) tick();
        check(first_oct == 8'h7E, "R1", "first octet", first_oct, 8'h7E);
        check(idle_flags >= 3, "R1", "idle flags before start", idle_flags, 3);

        en_mode = 0; send_msg(76, 2, 1'b0);
        en_mode = 1; send_msg(82, 0, 1'b0);   // R7: heavy stuffing
        en_mode = 2; send_msg(76, 1, 1'b1);   // R11 and R4 during message
        en_mode = 1; send_msg(82, 3, 1'b1);
        en_mode = 0; send_msg(76, 4, 1'b0);   // flag octets inside data
        en_mode = 1; send_msg(82, 2, 1'b0);

        while (exp_len.size() != 0) tick();
        idle_flags = 0;
        repeat (200) tick();
        check(idle_flags >= 10, "R8", "idle flags after last message", idle_flags, 10);
        check(frames_seen == 6, "R11", "frames sent", frames_seen, 6);
        check(busy == 1'b0, "R10", "busy after last message", busy, 0);
        check(stall_bad == 0, "R9", "tx_bit changes while bit_en low", stall_bad, 0);
        finish_run();
    end
endmodule